// File: doc/BRIEF.md
# Serial Data FIFO Pair with Event Interrupts

This block buffers the data between a register-access port and a serial shift engine. It holds one transmit queue and one receive queue, each 32 bytes deep. Software fills the transmit queue through a window register and drains the receive queue through another. The shifter pulls words from the transmit queue and pushes the words it receives into the receive queue. Both queues report their occupancy in bytes. In 16-bit word mode each word takes two bytes of capacity, so a queue then holds 16 words.

Six events are latched in a sticky status register: receive threshold reached, transmit queue drained, transfer end, transmit end, receive overflow and transmit underrun. Each event has an enable bit at the same position in a control register. The interrupt output is the OR of every status bit that is both set and enabled. The receive threshold is stored as a 3-bit code giving log2 of a word count, and a separate control bit gates the threshold logic.

Each queue tracks itself with a state machine whose states are FS_EMPTY, FS_PART and FS_FULL. From any state it moves to FS_EMPTY when its count becomes 0, to FS_FULL when its count reaches capacity, and to FS_PART otherwise. The threshold detector has two states: TS_BELOW and TS_MET. It moves from TS_BELOW to TS_MET when it is enabled and the level is at or above the threshold, and it emits the event on that transition. It moves from TS_MET back to TS_BELOW once that condition drops.

Top module: `sfq_hub`

## Requirements
- R1: After reset both levels read 0, the status and control registers read 0, and `irq` is 0.
- R2: A write to register address 5 pushes one word into the transmit queue. Register address 3 reads the transmit level in bytes. When the queue is full (32 words in byte mode, 16 words in word mode), a write is dropped and the level stays at 32.
- R3: A read of register address 4 returns the oldest receive word and pops it. When the receive queue is empty, the read returns 0 and the level at register address 2 stays 0.
- R4: Both queues keep first-in first-out order. In byte mode (`wide_mode`=0) only the low 8 bits of a word are stored. In word mode all 16 bits are stored.
- R5: Writing 0 to a level register (address 2 or 3) empties that queue. Writing any nonzero value to it has no effect.
- R6: Register address 6 bits [2:0] hold a code n, which sets a threshold of 2^n words. Status bit 0 sets one edge after the receive level first reaches the threshold. This happens only while control bit 16 is 1.
- R7: Status bit 4 sets when the transmit level goes from nonzero to zero, whether by a shifter pull or by a flush.
- R8: A shifter push into a full receive queue sets status bit 12 and drops the word.
- R9: A shifter pull from an empty transmit queue sets status bit 13 and presents 0 on `sh_tx_data`.
- R10: A pulse on `sh_xfer_end` sets status bit 8, and a pulse on `sh_tx_end` sets status bit 9.
- R11: Writing to the status register (address 1) clears each bit written as 1 and leaves each bit written as 0 unchanged. A new event in the same cycle wins over the clear.
- R12: `irq` is the OR of the status bits whose control enable bit (same position, address 0) is 1. A status bit still latches while its enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive window) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sh_rx_push | input | 1 | Shifter delivers a received word |
| sh_rx_data | input | 16 | Received word |
| sh_tx_pull | input | 1 | Shifter takes a transmit word |
| sh_tx_data | output | 16 | Head of the transmit queue, 0 when empty |
| sh_xfer_end | input | 1 | Transfer-end event pulse |
| sh_tx_end | input | 1 | Transmit-end event pulse |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check the following: occupancy bounds, that a flush empties a queue, that dropped pushes and pops leave the count unchanged, that overflow latches, that an underrun gives zero data, that status bits stay sticky until cleared, and that the threshold event is a single pulse. Only the bench scenarios can show the data order and the low-byte masking, the byte-level reporting in both modes, the exact threshold crossing and its gating bit, the ignored nonzero level writes and the priority of a set over a clear.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    localparam int EV_W      = 14;
    localparam int EV_RXTRG  = 0;
    localparam int EV_TXEMP  = 4;
    localparam int EV_XEND   = 8;
    localparam int EV_TEND   = 9;
    localparam int EV_OVF    = 12;
    localparam int EV_UND    = 13;
    localparam logic [EV_W-1:0] EV_MASK = 14'h3311;
    localparam int CTRL_TRGEN = 16;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_RXLVL = 3'd2,
        A_TXLVL = 3'd3,
        A_RXWIN = 3'd4,
        A_TXWIN = 3'd5,
        A_THR   = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_e;

    typedef enum logic {
        TS_BELOW = 1'b0,
        TS_MET   = 1'b1
    } trg_state_e;
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo
    import sfq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_lost,
    output logic          pop_dry
);
    localparam logic [CW-1:0] CAP_NARROW = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_WIDE   = CW'(DEPTH / 2);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt, cnt_nxt, cap;
    fifo_state_e   state, st_nxt;
    logic          do_push, do_pop;
    logic [DW-1:0] wmasked;

    assign cap     = wide ? CAP_WIDE : CAP_NARROW;
    assign do_push = push && (state != FS_FULL) && !flush;
    assign do_pop  = pop && (state != FS_EMPTY) && !flush;
    assign cnt_nxt = flush ? '0 : (cnt + CW'(do_push) - CW'(do_pop));
    assign wmasked = wide ? wdata : {{(DW-DW/2){1'b0}}, wdata[DW/2-1:0]};

    // next-state process
    always_comb begin
        st_nxt = state;
        unique case (state)
            FS_EMPTY: begin
                if (cnt_nxt != '0)
                    st_nxt = (cnt_nxt >= cap) ? FS_FULL : FS_PART;
            end
            FS_PART: begin
                if (cnt_nxt == '0)      st_nxt = FS_EMPTY;
                else if (cnt_nxt >= cap) st_nxt = FS_FULL;
            end
            FS_FULL: begin
                if (cnt_nxt == '0)      st_nxt = FS_EMPTY;
                else if (cnt_nxt < cap) st_nxt = FS_PART;
            end
            default: st_nxt = FS_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FS_EMPTY;
            cnt   <= '0;
            wp    <= '0;
            rp    <= '0;
        end else begin
            state <= st_nxt;
            cnt   <= cnt_nxt;
            if (flush) begin
                wp <= '0;
                rp <= '0;
            end else begin
                if (do_push) wp <= wp + 1'b1;
                if (do_pop)  rp <= rp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wmasked;
    end

    // output process
    always_comb begin
        full      = (state == FS_FULL);
        empty     = (state == FS_EMPTY);
        count     = cnt;
        rdata     = empty ? '0 : mem[rp];
        push_lost = push && full;
        pop_dry   = pop && empty;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP_NARROW);
    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(cnt));
    p_dry_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (cnt == '0));
endmodule

// File: rtl/sfq_rx_trigger.sv
module sfq_rx_trigger
    import sfq_pkg::*;
#(
    parameter int CW = 6,
    localparam int TW = (CW > 8) ? CW : 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [2:0]    code,
    input  logic [CW-1:0] level,
    output logic          fire
);
    trg_state_e    state, st_nxt;
    logic [TW-1:0] thr, lvl_w;
    logic          hit;

    assign thr   = TW'(1) << code;
    assign lvl_w = TW'(level);
    assign hit   = en && (lvl_w >= thr);

    always_comb begin
        st_nxt = state;
        unique case (state)
            TS_BELOW: if (hit)  st_nxt = TS_MET;
            TS_MET:   if (!hit) st_nxt = TS_BELOW;
            default:  st_nxt = TS_BELOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TS_BELOW;
        else        state <= st_nxt;
    end

    always_comb begin
        fire = (state == TS_BELOW) && hit;
    end

    p_fire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    p_fire_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !fire);
endmodule

// File: rtl/sfq_events.sv
module sfq_events
    import sfq_pkg::*;
#(
    parameter int EW = EV_W,
    parameter logic [EW-1:0] MASK = EV_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] set_ev,
    input  logic          clr_we,
    input  logic [EW-1:0] clr_bits,
    input  logic          en_we,
    input  logic [EW-1:0] en_bits,
    output logic [EW-1:0] status,
    output logic [EW-1:0] enable,
    output logic          irq
);
    logic [EW-1:0] clr_eff, st_nxt;

    assign clr_eff = clr_we ? clr_bits : '0;
    assign st_nxt  = ((status & ~clr_eff) | set_ev) & MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= st_nxt;
            if (en_we) enable <= en_bits & MASK;
        end
    end

    assign irq = |(status & enable);

    for (genvar k = 0; k < EW; k++) begin : g_chk
        if (MASK[k]) begin : g_live
            p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (status[k] && !(clr_we && clr_bits[k])) |=> status[k]);
            p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
                set_ev[k] |=> status[k]);
        end
    end
    p_irq_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);
endmodule

// File: rtl/sfq_hub.sv
module sfq_hub
    import sfq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int BYTES = 32,
    localparam int DEPTH = BYTES,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          sh_rx_push,
    input  logic [DW-1:0] sh_rx_data,
    input  logic          sh_tx_pull,
    output logic [DW-1:0] sh_tx_data,
    input  logic          sh_xfer_end,
    input  logic          sh_tx_end,
    output logic          irq
);
    reg_addr_e     addr;
    logic          wr_ctrl, wr_stat, wr_thr, rx_flush, tx_flush, rx_pop, tx_push;
    logic          trg_en, tx_empty_q, tx_drain;
    logic [2:0]    thr_code;
    logic [DW-1:0] rx_head;
    logic [CW-1:0] rx_cnt, tx_cnt, rx_lvl, tx_lvl;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic          rx_lost, rx_dry_unused, tx_lost_unused, tx_dry, rx_fire;
    logic [EV_W-1:0] ev_set, status, enable;

    assign addr     = reg_addr_e'(reg_addr);
    assign wr_ctrl  = reg_wr && (addr == A_CTRL);
    assign wr_stat  = reg_wr && (addr == A_STAT);
    assign wr_thr   = reg_wr && (addr == A_THR);
    assign rx_flush = reg_wr && (addr == A_RXLVL) && (reg_wdata == '0);
    assign tx_flush = reg_wr && (addr == A_TXLVL) && (reg_wdata == '0);
    assign rx_pop   = reg_rd && (addr == A_RXWIN);
    assign tx_push  = reg_wr && (addr == A_TXWIN);

    sfq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .wide(wide_mode),
        .push(sh_rx_push), .wdata(sh_rx_data), .pop(rx_pop), .flush(rx_flush),
        .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .push_lost(rx_lost), .pop_dry(rx_dry_unused)
    );

    sfq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .wide(wide_mode),
        .push(tx_push), .wdata(reg_wdata[DW-1:0]), .pop(sh_tx_pull), .flush(tx_flush),
        .rdata(sh_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .push_lost(tx_lost_unused), .pop_dry(tx_dry)
    );

    sfq_rx_trigger #(.CW(CW)) u_trg (
        .clk(clk), .rst_n(rst_n), .en(trg_en), .code(thr_code),
        .level(rx_cnt), .fire(rx_fire)
    );

    // configuration and drain-edge registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trg_en     <= 1'b0;
            thr_code   <= '0;
            tx_empty_q <= 1'b1;
        end else begin
            tx_empty_q <= tx_empty;
            if (wr_ctrl) trg_en   <= reg_wdata[CTRL_TRGEN];
            if (wr_thr)  thr_code <= reg_wdata[2:0];
        end
    end

    assign tx_drain = tx_empty && !tx_empty_q;

    always_comb begin
        ev_set           = '0;
        ev_set[EV_RXTRG] = rx_fire;
        ev_set[EV_TXEMP] = tx_drain;
        ev_set[EV_XEND]  = sh_xfer_end;
        ev_set[EV_TEND]  = sh_tx_end;
        ev_set[EV_OVF]   = rx_lost;
        ev_set[EV_UND]   = tx_dry;
    end

    sfq_events #(.EW(EV_W), .MASK(EV_MASK)) u_ev (
        .clk(clk), .rst_n(rst_n), .set_ev(ev_set),
        .clr_we(wr_stat), .clr_bits(reg_wdata[EV_W-1:0]),
        .en_we(wr_ctrl), .en_bits(reg_wdata[EV_W-1:0]),
        .status(status), .enable(enable), .irq(irq)
    );

    assign rx_lvl = wide_mode ? (rx_cnt << 1) : rx_cnt;
    assign tx_lvl = wide_mode ? (tx_cnt << 1) : tx_cnt;

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            A_CTRL:  begin
                reg_rdata[EV_W-1:0]  = enable;
                reg_rdata[CTRL_TRGEN] = trg_en;
            end
            A_STAT:  reg_rdata = 32'(status);
            A_RXLVL: reg_rdata = 32'(rx_lvl);
            A_TXLVL: reg_rdata = 32'(tx_lvl);
            A_RXWIN: reg_rdata = 32'(rx_head);
            A_TXWIN: reg_rdata = '0;
            A_THR:   reg_rdata = 32'(thr_code);
            default: reg_rdata = '0;
        endcase
    end

    p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_rx_push && rx_full) |=> status[EV_OVF]);
    p_underrun_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_tx_pull && tx_empty) |-> (sh_tx_data == '0));
    p_underrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_tx_pull && tx_empty) |=> status[EV_UND]);
    p_drain_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !tx_empty) |=> ##1 status[EV_TXEMP]);
    p_rx_full_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> (rx_lvl == CW'(BYTES)));
endmodule

// File: tb/sim_sfq_hub.sv
module sim_sfq_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sh_rx_push = 1'b0, sh_tx_pull = 1'b0;
    logic [15:0] sh_rx_data = '0;
    logic [15:0] sh_tx_data;
    logic        sh_xfer_end = 1'b0, sh_tx_end = 1'b0;
    logic        irq;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;
    logic [15:0] exp_tx[$];
    logic [15:0] exp_rx[$];

    always #5 clk = ~clk;

    sfq_hub u0 (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
        .sh_tx_pull(sh_tx_pull), .sh_tx_data(sh_tx_data),
        .sh_xfer_end(sh_xfer_end), .sh_tx_end(sh_tx_end), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cap();
        return wide_mode ? 16 : 32;
    endfunction

    function automatic logic [15:0] fold(input logic [15:0] d);
        return wide_mode ? d : {8'h00, d[7:0]};
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx_put(input logic [15:0] d);
        if (exp_tx.size() < cap()) exp_tx.push_back(fold(d));
        reg_write(3'd5, 32'(d));
    endtask

    task automatic tx_take();
        @(negedge clk);
        sh_tx_pull = 1'b1;
        @(negedge clk);
        sh_tx_pull = 1'b0;
    endtask

    task automatic rx_give(input logic [15:0] d);
        if (exp_rx.size() < cap()) exp_rx.push_back(fold(d));
        @(negedge clk);
        sh_rx_push = 1'b1; sh_rx_data = d;
        @(negedge clk);
        sh_rx_push = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] e);
        logic [31:0] v;
        reg_read(a, v);
        chk(req, v, e);
    endtask

    // monitor: compares data leaving the queues against the scoreboard
    always @(posedge clk) begin
        if (rst_n && sh_tx_pull) begin
            if (exp_tx.size() == 0) chk("R9 underrun data", 32'(sh_tx_data), 32'h0);
            else chk("R4 tx order", 32'(sh_tx_data), 32'(exp_tx.pop_front()));
        end
        if (rst_n && reg_rd && reg_addr == 3'd4) begin
            if (exp_rx.size() == 0) chk("R3 empty window", reg_rdata, 32'h0);
            else chk("R4 rx order", reg_rdata, 32'(exp_rx.pop_front()));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        expect_reg("R1 rx level", 3'd2, 0);
        expect_reg("R1 tx level", 3'd3, 0);
        expect_reg("R1 status", 3'd1, 0);
        expect_reg("R1 ctrl", 3'd0, 0);
        chk("R1 irq", 32'(irq), 0);

        // byte mode transmit, masking and drain event
        tx_put(16'h01A5); tx_put(16'h0022); tx_put(16'h0033);
        expect_reg("R2 tx level", 3'd3, 3);
        repeat (3) tx_take();
        expect_reg("R7 drain status", 3'd1, 32'h10);
        chk("R12 latch while disabled", 32'(irq), 0);
        reg_write(3'd0, 32'h10);
        chk("R12 irq enabled", 32'(irq), 1);
        reg_write(3'd1, 32'h10);
        expect_reg("R11 w1c", 3'd1, 0);
        chk("R12 irq cleared", 32'(irq), 0);
        reg_write(3'd0, 32'h0);

        // underrun
        tx_take();
        expect_reg("R9 underrun status", 3'd1, 32'h2000);
        reg_write(3'd1, 32'h2000);

        // full byte queue, ignored level write, flush
        for (int i = 0; i < 33; i++) tx_put(16'(i + 1));
        expect_reg("R2 full level", 3'd3, 32);
        reg_write(3'd3, 32'd5);
        expect_reg("R5 nonzero ignored", 3'd3, 32);
        reg_write(3'd3, 32'd0);
        exp_tx.delete();
        expect_reg("R5 flush", 3'd3, 0);
        expect_reg("R7 flush drain", 3'd1, 32'h10);
        reg_write(3'd1, 32'h10);

        // word mode
        @(negedge clk) wide_mode = 1'b1;
        for (int i = 0; i < 17; i++) tx_put(16'h1000 + 16'(i) * 16'h0111);
        expect_reg("R2 word mode level", 3'd3, 32);
        repeat (16) tx_take();
        expect_reg("R7 word drain", 3'd1, 32'h10);
        reg_write(3'd1, 32'h10);
        @(negedge clk) wide_mode = 1'b0;

        // receive threshold 2^2 = 4 words
        reg_write(3'd6, 32'd2);
        reg_write(3'd0, 32'h10000);
        for (int i = 0; i < 3; i++) rx_give(16'h0140 + 16'(i));
        expect_reg("R6 below threshold", 3'd1, 0);
        rx_give(16'h0143);
        expect_reg("R6 threshold met", 3'd1, 32'h1);
        expect_reg("R3 rx level", 3'd2, 4);
        begin
            logic [31:0] v;
            for (int i = 0; i < 5; i++) reg_read(3'd4, v);
        end
        expect_reg("R3 empty read no change", 3'd2, 0);
        reg_write(3'd1, 32'h1);

        // threshold disabled
        reg_write(3'd0, 32'h0);
        for (int i = 0; i < 4; i++) rx_give(16'h0050 + 16'(i));
        expect_reg("R6 gated off", 3'd1, 0);
        reg_write(3'd2, 32'd0);
        exp_rx.delete();
        expect_reg("R5 rx flush", 3'd2, 0);

        // overflow
        for (int i = 0; i < 33; i++) rx_give(16'(i + 16'h0200));
        expect_reg("R8 overflow status", 3'd1, 32'h1000);
        expect_reg("R8 level capped", 3'd2, 32);
        begin
            logic [31:0] v;
            for (int i = 0; i < 32; i++) reg_read(3'd4, v);
        end
        reg_write(3'd1, 32'h1000);

        // shifter events, w1c of zeros, set over clear
        @(negedge clk) sh_xfer_end = 1'b1;
        @(negedge clk) sh_xfer_end = 1'b0;
        expect_reg("R10 xfer end", 3'd1, 32'h100);
        @(negedge clk) sh_tx_end = 1'b1;
        @(negedge clk) sh_tx_end = 1'b0;
        expect_reg("R10 tx end", 3'd1, 32'h300);
        reg_write(3'd1, 32'h0);
        expect_reg("R11 zero write keeps", 3'd1, 32'h300);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h100; sh_xfer_end = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; sh_xfer_end = 1'b0;
        expect_reg("R11 set wins", 3'd1, 32'h300);
        reg_write(3'd0, 32'h100);
        chk("R12 enabled bit8", 32'(irq), 1);
        reg_write(3'd1, 32'h100);
        expect_reg("R11 clear bit8", 3'd1, 32'h200);
        chk("R12 bit9 not enabled", 32'(irq), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule